// File: doc/BRIEF.md
# Chained Counter Pulse Period Meter

This block joins two up-counters into one extended timebase and uses it to measure the period of an outside pulse train. The low counter advances once every (divider + 1) clocks and returns to zero after it reaches its programmable wrap value. At that moment it raises a one-cycle update pulse. The high counter has no divider of its own. It moves only on that update pulse, so the pair behaves as a single wide counter whose value is high × (low wrap + 1) + low.

A measured input arrives without any timing relation to the clock. It passes through a two-stage synchronizer and a rising-edge detector. The first rising edge it produces clears the divider and both counters and arms the sequencer. The next rising edge takes a snapshot of both counters and disarms it, so the edges after that alternate between starting and ending a measurement. A snapshot taken in the same cycle as a rollover already includes that rollover. The live count is available at all times as a concatenation of the two counters.

Top module: `cascade_period_meter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the live count, both captured counts and the capture-valid strobe are zero and the sequencer is idle.
- R2: With divider value D, the low counter advances by one every D+1 clocks, counting from reset or from the most recent clear.
- R3: The low counter wraps to zero on the tick on which it holds the low wrap value R, and that tick produces a one-cycle update pulse.
- R4: The high counter advances by exactly one on each update pulse and holds its value in every other cycle.
- R5: The high counter returns to zero when an update pulse arrives while it holds the high wrap value H.
- R6: live_cnt_o carries the high counter in bits [31:16] and the low counter in bits [15:0].
- R7: A rising edge on meas_i reaches the sequencer through a two-flop synchronizer and an edge detector. The latency is the same for every edge, so the measured interval equals the spacing of the input edges in clocks.
- R8: A detected rising edge while the sequencer is idle clears the divider and both counters on that clock and arms the sequencer.
- R9: A detected rising edge while the sequencer is armed latches the values the counters take on that clock, rollover included. For edges P clocks apart, the latched values satisfy cap_hi × (R+1) + cap_lo = floor(P/(D+1)) mod ((H+1)(R+1)).
- R10: cap_valid_o is high for exactly one cycle, in the cycle after the second-edge latch. It never follows a first edge.
- R11: After a capture the sequencer is idle again, so the next rising edge starts a fresh measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| div_i | input | 16 | Divider value D; the tick period is D+1 clocks |
| lo_wrap_i | input | 16 | Low counter wrap value R |
| hi_wrap_i | input | 16 | High counter wrap value H |
| meas_i | input | 1 | Asynchronous signal whose period is measured |
| cap_lo_o | output | 16 | Low count latched at the second edge |
| cap_hi_o | output | 16 | High count latched at the second edge |
| cap_valid_o | output | 1 | One-cycle strobe marking a new capture |
| live_cnt_o | output | 32 | Live combined count {high, low} |

## Verification
A miscounting divider or low counter shows up in the captured low value as soon as the first measurement ends. It also shows up in the live count within D+1 clocks of reset. A high counter that moves without an update pulse, or a sequencer left in the wrong phase, shows up in the next capture. The sequencer fault appears as a missing or early valid strobe, or as a count taken from the wrong starting edge. The sweep sets edge spacings so that captures land exactly on low rollovers and high wraps. An off-by-one in the snapshot timing therefore changes cap_hi_o and cap_lo_o at once.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_ARMED = 1'b1} phase_t;
endpackage

// File: rtl/cpm_prescaler.sv
module cpm_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] ph_q;

  assign tick_o = !clr && (ph_q >= div_i);

  always_ff @(posedge clk) begin
    if (rst || clr)  ph_q <= '0;
    else if (tick_o) ph_q <= '0;
    else             ph_q <= ph_q + 1'b1;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/cpm_wrap_counter.sv
module cpm_wrap_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] wrap_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  function automatic logic [W-1:0] step(input logic [W-1:0] cur,
                                        input logic [W-1:0] lim,
                                        input logic go, input logic zap);
    if (zap)             return '0;
    else if (!go)        return cur;
    else if (cur >= lim) return '0;
    else                 return cur + 1'b1;
  endfunction

  assign nxt_o  = step(cnt_q, wrap_i, en, clr);
  assign wrap_o = en && !clr && (cnt_q >= wrap_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= nxt_o;
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt_q));
  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/cpm_edge_sync.sv
module cpm_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0; s2_q <= 1'b0; s3_q <= 1'b0;
    end else begin
      s1_q <= async_i; s2_q <= s1_q; s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q && !s3_q;

  // R7
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cpm_capture_seq.sv
module cpm_capture_seq
  import cpm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise_i,
  input  logic [W-1:0] lo_nxt_i,
  input  logic [W-1:0] hi_nxt_i,
  output logic         clr_o,
  output logic [W-1:0] cap_lo_o,
  output logic [W-1:0] cap_hi_o,
  output logic         valid_o
);
  phase_t ph_q;
  logic   latch_w;

  assign clr_o   = rise_i && (ph_q == PH_IDLE);
  assign latch_w = rise_i && (ph_q == PH_ARMED);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      cap_lo_o <= '0;
      cap_hi_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= latch_w;
      if (clr_o) ph_q <= PH_ARMED;
      if (latch_w) begin
        ph_q     <= PH_IDLE;
        cap_lo_o <= lo_nxt_i;
        cap_hi_o <= hi_nxt_i;
      end
    end
  end

  // R8
  arm_chk: assert property (@(posedge clk) disable iff (rst)
    clr_o |=> (ph_q == PH_ARMED) && !valid_o);
  // R10
  strobe_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R11
  disarm_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (ph_q == PH_IDLE));
endmodule

// File: rtl/cascade_period_meter.sv
module cascade_period_meter #(
  parameter int CW = 16,
  parameter int PW = 16,
  localparam int LW = 2 * CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] div_i,
  input  logic [CW-1:0] lo_wrap_i,
  input  logic [CW-1:0] hi_wrap_i,
  input  logic          meas_i,
  output logic [CW-1:0] cap_lo_o,
  output logic [CW-1:0] cap_hi_o,
  output logic          cap_valid_o,
  output logic [LW-1:0] live_cnt_o
);
  logic          tick_w, upd_w, hi_wrap_w, rise_w, clr_w;
  logic [CW-1:0] lo_w, hi_w, lo_nxt_w, hi_nxt_w;

  cpm_edge_sync u_sync (.clk(clk), .rst(rst), .async_i(meas_i), .rise_o(rise_w));

  cpm_prescaler #(.W(PW)) u_div (
    .clk(clk), .rst(rst), .clr(clr_w), .div_i(div_i), .tick_o(tick_w));

  cpm_wrap_counter #(.W(CW)) u_lo (
    .clk(clk), .rst(rst), .clr(clr_w), .en(tick_w), .wrap_i(lo_wrap_i),
    .cnt_o(lo_w), .nxt_o(lo_nxt_w), .wrap_o(upd_w));

  cpm_wrap_counter #(.W(CW)) u_hi (
    .clk(clk), .rst(rst), .clr(clr_w), .en(upd_w), .wrap_i(hi_wrap_i),
    .cnt_o(hi_w), .nxt_o(hi_nxt_w), .wrap_o(hi_wrap_w));

  cpm_capture_seq #(.W(CW)) u_seq (
    .clk(clk), .rst(rst), .rise_i(rise_w), .lo_nxt_i(lo_nxt_w),
    .hi_nxt_i(hi_nxt_w), .clr_o(clr_w), .cap_lo_o(cap_lo_o),
    .cap_hi_o(cap_hi_o), .valid_o(cap_valid_o));

  assign live_cnt_o = {hi_w, lo_w};

  // R4
  hi_step_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_w && !hi_wrap_w) |=> (hi_w == CW'($past(hi_w) + 1'b1)));
  // R5
  hi_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    hi_wrap_w |=> (hi_w == '0));
  // R3
  upd_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    upd_w |-> (tick_w && !clr_w));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_w |=> (live_cnt_o == '0));
endmodule

// File: tb/cascade_period_meter_tb_top.sv
module cascade_period_meter_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] div_i, lo_wrap_i, hi_wrap_i;
  logic        meas_i;
  logic [15:0] cap_lo_o, cap_hi_o;
  logic        cap_valid_o;
  logic [31:0] live_cnt_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cascade_period_meter dut_i (
    .clk(clk), .rst(rst), .div_i(div_i), .lo_wrap_i(lo_wrap_i),
    .hi_wrap_i(hi_wrap_i), .meas_i(meas_i), .cap_lo_o(cap_lo_o),
    .cap_hi_o(cap_hi_o), .cap_valid_o(cap_valid_o), .live_cnt_o(live_cnt_o));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint fold(input int ticks, input int r, input int h);
    int m;
    m = ticks % ((h + 1) * (r + 1));
    return longint'((m / (r + 1)) * 65536 + (m % (r + 1)));
  endfunction

  task automatic do_reset(input int d, input int r, input int h);
    @(negedge clk);
    rst = 1'b1; meas_i = 1'b0;
    div_i = 16'(d); lo_wrap_i = 16'(r); hi_wrap_i = 16'(h);
    repeat (3) @(negedge clk);
    // R1: outputs cleared while in reset
    check("R1 live", live_cnt_o, 0);
    check("R1 cap", {cap_hi_o, cap_lo_o}, 0);
    check("R1 valid", cap_valid_o, 0);
    rst = 1'b0;
  endtask

  // R2 R3 R4 R5 R6: free-running count after reset
  task automatic free_run(input int d, input int r, input int h, input int n);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      check("R2/R6 live", live_cnt_o, fold(k / (d + 1), r, h));
    end
  endtask

  // R7 R8 R9 R10 R11: one two-edge measurement with edges p clocks apart
  task automatic measure(input int d, input int r, input int h, input int p);
    bit seen;
    meas_i = 1'b1;
    @(negedge clk); meas_i = 1'b1;
    @(negedge clk); meas_i = 1'b0;
    for (int k = 2; k < p; k++) begin
      @(negedge clk);
      // R10: no strobe after a first edge
      if (cap_valid_o) check("R10 early valid", 1, 0);
    end
    meas_i = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 6 && !seen; k++) begin
      @(negedge clk);
      if (cap_valid_o) seen = 1'b1;
    end
    check("R10 valid seen", seen, 1);
    check("R9 capture", {cap_hi_o, cap_lo_o}, fold(p / (d + 1), r, h));
    @(negedge clk);
    check("R10 one-cycle", cap_valid_o, 0);
    meas_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; meas_i = 1'b0;
    div_i = '0; lo_wrap_i = '0; hi_wrap_i = '0;
    for (int d = 0; d <= 2; d++)
      for (int ri = 0; ri < 3; ri++)
        for (int h = 1; h <= 3; h += 2) begin
          automatic int r = (ri == 0) ? 2 : (ri == 1) ? 3 : 5;
          do_reset(d, r, h);
          free_run(d, r, h, 40);
          // R11: consecutive measurements each start afresh
          for (int p = 4; p <= 20; p++) measure(d, r, h, p);
        end
    // R5 R9: rollover coincident with capture, then a high wrap
    do_reset(0, 3, 1);
    measure(0, 3, 1, 8);
    measure(0, 3, 1, 9);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule